// File: doc/BRIEF.md
# USB Endpoint Configuration and Device Address Unit

This register unit sits inside a full-speed USB peripheral controller, behind the byte-wide command/data port that a local microcontroller drives. The microcontroller first strobes a command byte, then strobes exactly one data byte. That data byte is either written into the selected register or read back from it. The unit holds sixteen endpoint configuration bytes and one device address byte. The endpoints are, in code order, control OUT, control IN, and endpoints 1 to 14. A write that changes how endpoint memory is allocated raises a one-cycle FIFO-invalidate pulse. Every endpoint's FIFO contents become stale on that pulse.

The address the serial engine matches against is kept apart from the register that the microcontroller sees. A newly written address waits as pending until the host acknowledges the empty status-stage packet. Only then does it become active. A USB bus reset drives the active address to zero and enables the device. The bus reset does not touch the microcontroller-visible register.

Top module: `usb_epcfg_addr_unit`

## Requirements
- R1: After `rst_n` is released, every configuration byte and the address register read back 0x00. `act_addr` is 0, `dev_en` is 0, `fifo_inval` is 0 and `rd_data` is 0x00.
- R2: A command byte 0x20+n (n = 0..15) selects configuration byte n for writing, and 0x30+n selects it for reading. Byte 0 is control OUT, byte 1 is control IN and byte n+1 is endpoint n. When a read is selected, the value appears on `rd_data` after the clock edge that samples `rd_strobe`. `rd_data` holds its value in every other cycle.
- R3: All eight bits of a configuration byte are stored and returned unchanged: bit 7 enable, bit 6 direction, bit 5 double buffer, bit 4 isochronous, bits 3:0 size.
- R4: A configuration write pulses `fifo_inval` high for exactly one cycle, the cycle after the write edge, when it changes bit 7, bit 5 or any of bits 3:0 of that byte. A write that changes only bit 6 and/or bit 4, or changes nothing, gives no pulse.
- R5: Command 0xB6 selects the address register for writing and 0xB7 selects it for reading. Bit 7 is the device enable and bits 6:0 are the address.
- R6: An address write leaves `act_addr` and `dev_en` unchanged. On the first edge that samples `status_ack` while an address is pending, `act_addr` takes register bits 6:0 and `dev_en` takes bit 7. `status_ack` with nothing pending has no effect.
- R7: When several address writes come before the acknowledgement, the most recently written value is the one activated.
- R8: A sampled `usb_bus_rst` sets `act_addr` to 0 and `dev_en` to 1 on that edge and discards any pending activation. It leaves the address register's read-back value unchanged. It takes priority over a same-cycle `status_ack`, and over the activation request of a same-cycle address write.
- R9: A command code outside 0x20..0x3F, 0xB6 and 0xB7 selects nothing, so a following data strobe changes no register and no output. After one data strobe the selection is cleared, and a second data strobe is ignored.
- R10: When an address write and `status_ack` are sampled on the same edge, the value that was already pending is activated. The newly written value then stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_strobe | input | 1 | Command byte valid |
| cmd_code | input | 8 | Command byte |
| wr_strobe | input | 1 | Data write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_strobe | input | 1 | Data read strobe |
| rd_data | output | 8 | Read-back byte, registered |
| status_ack | input | 1 | Host acknowledged the empty status packet |
| usb_bus_rst | input | 1 | USB bus reset detected |
| act_addr | output | 7 | Active device address used for matching |
| dev_en | output | 1 | Device enabled for matching |
| fifo_inval | output | 1 | One-cycle pulse: all FIFO contents invalid |

## Verification
The status acknowledgement can coincide with an address write, and it can also coincide with a bus reset. Both collisions decide which address ends up active. The bench raises the write strobe and `status_ack` together, and it raises `status_ack` together with `usb_bus_rst`. A scoreboard model of the pending flag predicts the outcome. `act_addr` and `dev_en` are then compared after that edge and again after a later acknowledgement.

// File: rtl/usb_epcfg_pkg.sv
package usb_epcfg_pkg;
    localparam int NUM_EP   = 16;
    localparam int IDX_W    = $clog2(NUM_EP);
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = BYTE_W - 1;

    localparam logic [3:0]        NIB_EP_WR  = 4'h2;
    localparam logic [3:0]        NIB_EP_RD  = 4'h3;
    localparam logic [BYTE_W-1:0] CODE_AD_WR = 8'hB6;
    localparam logic [BYTE_W-1:0] CODE_AD_RD = 8'hB7;

    // enable, double buffer and size bits decide memory allocation
    localparam logic [BYTE_W-1:0] ALLOC_MASK = 8'hAF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EP_WR,
        SEL_EP_RD,
        SEL_AD_WR,
        SEL_AD_RD
    } sel_kind_e;
endpackage

// File: rtl/usb_epcfg_cmd_decode.sv
module usb_epcfg_cmd_decode
    import usb_epcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_strobe,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              wr_strobe,
    input  logic              rd_strobe,
    output logic              ep_we,
    output logic              ep_re,
    output logic              ad_we,
    output logic              ad_re,
    output logic [IDX_W-1:0]  sel_idx
);
    typedef struct packed {
        sel_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } dec_state_t;

    dec_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_strobe || rd_strobe) begin
            s_d.kind = SEL_NONE;
        end
        if (cmd_strobe) begin
            s_d.idx = cmd_code[IDX_W-1:0];
            if (cmd_code[7:4] == NIB_EP_WR)       s_d.kind = SEL_EP_WR;
            else if (cmd_code[7:4] == NIB_EP_RD)  s_d.kind = SEL_EP_RD;
            else if (cmd_code == CODE_AD_WR)      s_d.kind = SEL_AD_WR;
            else if (cmd_code == CODE_AD_RD)      s_d.kind = SEL_AD_RD;
            else                                  s_d.kind = SEL_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.kind <= SEL_NONE;
            s_q.idx  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ep_we   = wr_strobe && (s_q.kind == SEL_EP_WR);
    assign ep_re   = rd_strobe && (s_q.kind == SEL_EP_RD);
    assign ad_we   = wr_strobe && (s_q.kind == SEL_AD_WR);
    assign ad_re   = rd_strobe && (s_q.kind == SEL_AD_RD);
    assign sel_idx = s_q.idx;
endmodule

// File: rtl/usb_epcfg_bank.sv
module usb_epcfg_bank
    import usb_epcfg_pkg::*;
#(
    parameter int N_EP = NUM_EP,
    parameter int IW   = $clog2(N_EP),
    parameter int BW   = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output logic          inval
);
    typedef struct packed {
        logic [N_EP-1:0][BW-1:0] cfg;
        logic                    inval;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [N_EP-1:0][BW-1:0] cfg_next;
    logic [BW-1:0]           cur_byte;

    for (genvar g = 0; g < N_EP; g++) begin : g_slot
        assign cfg_next[g] = (we && (idx == IW'(g))) ? wdata : s_q.cfg[g];
    end

    assign cur_byte = s_q.cfg[idx];

    always_comb begin
        s_d       = s_q;
        s_d.cfg   = cfg_next;
        s_d.inval = we && (|((cur_byte ^ wdata) & ALLOC_MASK[BW-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = cur_byte;
    assign inval = s_q.inval;
endmodule

// File: rtl/usb_epcfg_addr_ctrl.sv
module usb_epcfg_addr_ctrl
    import usb_epcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              status_ack,
    input  logic              usb_bus_rst,
    output logic [BYTE_W-1:0] reg_val,
    output logic [ADDR_W-1:0] act_addr,
    output logic              dev_en
);
    typedef struct packed {
        logic [BYTE_W-1:0] regv;
        logic              pend;
        logic [ADDR_W-1:0] act;
        logic              en;
    } addr_state_t;

    addr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.regv = wdata;
        end
        if (usb_bus_rst) begin
            s_d.act  = '0;
            s_d.en   = 1'b1;
            s_d.pend = 1'b0;
        end else begin
            if (status_ack && s_q.pend) begin
                // pending value is the register as it stood before this edge
                s_d.act  = s_q.regv[ADDR_W-1:0];
                s_d.en   = s_q.regv[BYTE_W-1];
                s_d.pend = 1'b0;
            end
            if (we) begin
                s_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_val  = s_q.regv;
    assign act_addr = s_q.act;
    assign dev_en   = s_q.en;
endmodule

// File: rtl/usb_epcfg_addr_unit.sv
module usb_epcfg_addr_unit
    import usb_epcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_strobe,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              wr_strobe,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              status_ack,
    input  logic              usb_bus_rst,
    output logic [ADDR_W-1:0] act_addr,
    output logic              dev_en,
    output logic              fifo_inval
);
    typedef struct packed {
        logic [BYTE_W-1:0] rd;
    } top_state_t;

    top_state_t s_d, s_q;

    logic             ep_we, ep_re, ad_we, ad_re;
    logic [IDX_W-1:0] sel_idx;
    logic [BYTE_W-1:0] ep_rdata, ad_reg;

    usb_epcfg_cmd_decode i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_strobe (cmd_strobe),
        .cmd_code   (cmd_code),
        .wr_strobe  (wr_strobe),
        .rd_strobe  (rd_strobe),
        .ep_we      (ep_we),
        .ep_re      (ep_re),
        .ad_we      (ad_we),
        .ad_re      (ad_re),
        .sel_idx    (sel_idx)
    );

    usb_epcfg_bank #(
        .N_EP (NUM_EP),
        .IW   (IDX_W),
        .BW   (BYTE_W)
    ) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ep_we),
        .idx   (sel_idx),
        .wdata (wr_data),
        .rdata (ep_rdata),
        .inval (fifo_inval)
    );

    usb_epcfg_addr_ctrl i_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (ad_we),
        .wdata       (wr_data),
        .status_ack  (status_ack),
        .usb_bus_rst (usb_bus_rst),
        .reg_val     (ad_reg),
        .act_addr    (act_addr),
        .dev_en      (dev_en)
    );

    always_comb begin
        s_d = s_q;
        if (ep_re)      s_d.rd = ep_rdata;
        else if (ad_re) s_d.rd = ad_reg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;
endmodule

// File: rtl/usb_epcfg_addr_chk.sv
module usb_epcfg_addr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_strobe,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input logic       status_ack,
    input logic       usb_bus_rst,
    input logic [6:0] act_addr,
    input logic       dev_en,
    input logic       fifo_inval
);
    assert_inval_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_inval |=> !fifo_inval);

    assert_inval_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_inval |-> $past(wr_strobe));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_ack && !usb_bus_rst) |=> ($stable(act_addr) && $stable(dev_en)));

    assert_bus_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        usb_bus_rst |=> (act_addr == 7'd0 && dev_en));
endmodule

bind usb_epcfg_addr_unit usb_epcfg_addr_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_strobe   (wr_strobe),
    .rd_strobe   (rd_strobe),
    .rd_data     (rd_data),
    .status_ack  (status_ack),
    .usb_bus_rst (usb_bus_rst),
    .act_addr    (act_addr),
    .dev_en      (dev_en),
    .fifo_inval  (fifo_inval)
);

// File: tb/test_usb_epcfg_addr_unit.sv
module test_usb_epcfg_addr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_strobe = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       status_ack = 1'b0;
    logic       usb_bus_rst = 1'b0;
    logic [6:0] act_addr;
    logic       dev_en;
    logic       fifo_inval;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_ep [16];
    logic [7:0] m_reg  = 8'h00;
    logic       m_pend = 1'b0;
    logic [6:0] m_act  = 7'd0;
    logic       m_en   = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    usb_epcfg_addr_unit i_usb_epcfg_addr_unit (
        .clk (clk), .rst_n (rst_n), .cmd_strobe (cmd_strobe), .cmd_code (cmd_code),
        .wr_strobe (wr_strobe), .wr_data (wr_data), .rd_strobe (rd_strobe),
        .rd_data (rd_data), .status_ack (status_ack), .usb_bus_rst (usb_bus_rst),
        .act_addr (act_addr), .dev_en (dev_en), .fifo_inval (fifo_inval)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result against the scoreboard queue
    always @(posedge clk) rd_seen <= rd_strobe;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected read", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), {24'd0, rd_data}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk); cmd_strobe = 1'b1; cmd_code = c;
        @(negedge clk); cmd_strobe = 1'b0;
    endtask

    task automatic send_wr(input logic [7:0] d);
        @(negedge clk); wr_strobe = 1'b1; wr_data = d;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    task automatic send_rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic ep_write(input int idx, input logic [7:0] d, input string tag);
        logic exp_inv;
        exp_inv = |((m_ep[idx] ^ d) & 8'hAF);
        m_ep[idx] = d;
        send_cmd(8'h20 + 8'(idx));
        send_wr(d);
        chk({tag, " R4 pulse"}, {31'd0, fifo_inval}, {31'd0, exp_inv});
        @(negedge clk);
        chk({tag, " R4 one cycle"}, {31'd0, fifo_inval}, 32'd0);
    endtask

    task automatic ep_read(input int idx, input string tag);
        send_cmd(8'h30 + 8'(idx));
        send_rd(m_ep[idx], tag);
    endtask

    task automatic addr_write(input logic [7:0] d);
        m_reg = d; m_pend = 1'b1;
        send_cmd(8'hB6);
        send_wr(d);
    endtask

    task automatic give_ack();
        if (m_pend) begin m_act = m_reg[6:0]; m_en = m_reg[7]; m_pend = 1'b0; end
        @(negedge clk); status_ack = 1'b1;
        @(negedge clk); status_ack = 1'b0;
    endtask

    task automatic check_active(input string tag);
        chk({tag, " addr"}, {25'd0, act_addr}, {25'd0, m_act});
        chk({tag, " en"}, {31'd0, dev_en}, {31'd0, m_en});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) m_ep[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", {24'd0, rd_data}, 32'd0);
        chk("R1 fifo_inval", {31'd0, fifo_inval}, 32'd0);
        check_active("R1");
        ep_read(0, "R1 ep0 reset");
        ep_read(15, "R1 ep15 reset");
        send_cmd(8'hB7); send_rd(8'h00, "R1 addr reg reset");

        // R2/R3 writes and reads of several slots and patterns
        ep_write(0, 8'hC5, "R3 ep0");
        ep_write(15, 8'h5A, "R3 ep15");
        ep_write(5, 8'hFF, "R3 ep5");
        ep_read(0, "R2 ep0 readback");
        ep_read(15, "R2 ep15 readback");
        ep_read(5, "R3 ep5 readback");
        ep_read(1, "R2 ep1 untouched");

        // R4 direction/iso only: no pulse; size change: pulse; same value: no pulse
        ep_write(5, 8'hAF, "R4 dir+iso only");
        ep_write(5, 8'hAE, "R4 size change");
        ep_write(5, 8'hAE, "R4 unchanged");
        ep_write(5, 8'h8E, "R4 dblbuf change");
        ep_read(5, "R4 ep5 final");

        // R5/R6 address write is not active until ack
        addr_write(8'hA3);
        send_cmd(8'hB7); send_rd(8'hA3, "R5 addr readback");
        check_active("R6 before ack");
        give_ack();
        check_active("R6 after ack");
        give_ack();
        check_active("R6 ack with nothing pending");

        // R7 latest of several writes
        addr_write(8'h91);
        addr_write(8'h12);
        give_ack();
        check_active("R7 latest");

        // R8 bus reset: active cleared, enabled, register kept, pending dropped
        addr_write(8'h7C);
        @(negedge clk); usb_bus_rst = 1'b1; status_ack = 1'b1;
        m_act = 7'd0; m_en = 1'b1; m_pend = 1'b0;
        @(negedge clk); usb_bus_rst = 1'b0; status_ack = 1'b0;
        check_active("R8 bus reset over ack");
        send_cmd(8'hB7); send_rd(8'h7C, "R8 register kept");
        give_ack();
        check_active("R8 pending discarded");

        // R10 same-cycle address write and ack
        addr_write(8'h85);
        send_cmd(8'hB6);
        @(negedge clk); wr_strobe = 1'b1; wr_data = 8'h46; status_ack = 1'b1;
        m_act = 7'h05; m_en = 1'b1; m_reg = 8'h46; m_pend = 1'b1;
        @(negedge clk); wr_strobe = 1'b0; status_ack = 1'b0;
        check_active("R10 old value activated");
        give_ack();
        check_active("R10 new value later");

        // R9 undefined code and repeated data strobe ignored
        send_cmd(8'h40);
        send_wr(8'h00);
        chk("R9 undefined no pulse", {31'd0, fifo_inval}, 32'd0);
        send_cmd(8'hB5);
        send_wr(8'h00);
        ep_read(0, "R9 ep0 unchanged");
        send_cmd(8'hB7); send_rd(8'h46, "R9 addr reg unchanged");
        ep_write(3, 8'h83, "R9 single write");
        send_wr(8'h00);
        chk("R9 second strobe no pulse", {31'd0, fifo_inval}, 32'd0);
        ep_read(3, "R9 ep3 after second strobe");
        check_active("R9 active unchanged");

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule